// File: doc/BRIEF.md
# SMBus Slave Register Read Bridge

This block sits behind a byte-level SMBus slave front end and lets a host fetch internal 32-bit control and status registers without any wait states on the bus. A fetch takes two transactions. First the host sends a block write that carries a command code, a byte count of 3, a command byte flagged as a read, and a 16-bit register address split into a low and a high byte. When STOP closes that write, the bridge places a read request on a simple request/acknowledge register port and waits for the data.

Second, the host sends a block read: its slave address with write, the command code, a repeated START, and its slave address with read. If the register data has not come back yet, the bridge refuses its own read address and the host retries later. Once the data is ready, the bridge returns a byte count of 7 followed by a status byte, the echoed address and four data bytes, least significant first. The host ends the read by refusing the last byte and sending STOP. No PEC byte is sent or expected, and register writes over SMBus are not supported.

The front end reports START, STOP and every received byte. It takes the acknowledge decision for a received byte from `rx_ack_o` in the same cycle, and it loads the next byte to send from `tx_byte_o`.

Top module: `smb_csr_bridge`

## Requirements
- R1: The bridge acknowledges an address byte only if bits 7:1 equal the slave address (default 7'h52). After an address byte is refused, every byte is refused until the next START. A byte received with no START before it is refused.
- R2: In the sequence address+write (bit 0 = 0), command code, count, command, address low, address high, every byte is acknowledged. If STOP follows, `req_o` goes high in the cycle after STOP with `req_addr_o` = {high, low}. It then holds high with a stable address until `rack_i` is seen.
- R3: A count byte other than 3 is refused, and a STOP after it issues no request.
- R4: A command byte with bit 0 = 0 (write) is refused, and a STOP after it issues no request.
- R5: A byte that arrives after the address high byte is refused, and a STOP that comes before the address high byte issues no request.
- R6: An address+read byte (bit 0 = 1) is refused while no data is ready. It is also refused when the same transaction did not acknowledge a command code before it.
- R7: Data becomes ready in the cycle after `rack_i`. An address+read is then acknowledged, and `tx_byte_o` presents in turn 7, status, address low, address high, then data 7:0, 15:8, 23:16 and 31:24. Each `tx_next_i` advances to the next byte. Status bit 0 is 1, bit 1 copies `rerr_i`, and the other bits are 0.
- R8: When `rerr_i` is high with `rack_i`, the four data bytes read as zero.
- R9: A new valid block write clears the ready state, so reads are refused again. If a request is still outstanding, the acknowledge for it is dropped, and the request is then reissued with the new address. Data becomes ready only after that reissued request is acknowledged.
- R10: After reset `req_o` is low and an address+read is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen, one-cycle pulse |
| stop_i | input | 1 | STOP seen, one-cycle pulse |
| rx_valid_i | input | 1 | A received byte is on rx_byte_i |
| rx_byte_i | input | 8 | Received byte |
| rx_ack_o | output | 1 | Acknowledge decision for the byte on rx_byte_i |
| tx_next_i | input | 1 | The current transmit byte has been sent |
| tx_byte_o | output | 8 | Byte to transmit |
| req_o | output | 1 | Register read request |
| req_addr_o | output | 16 | Register address |
| rack_i | input | 1 | Register read acknowledge, carries data |
| rdata_i | input | 32 | Register read data |
| rerr_i | input | 1 | Address invalid, qualifies rack_i |

## Verification
`rx_ack_o` is combinational, so the bench reads it 1 ns after it drives a byte, before the next clock edge. `req_o` and `req_addr_o` change at the edge that samples the STOP pulse. The ready state and the captured data change at the edge that samples `rack_i`. The transmit index resets at the edge that samples the acknowledged read address and steps at each edge that samples `tx_next_i`. Every input is driven at a falling edge and held for one full cycle, and every registered output is read at the next falling edge, which is exactly one register after the stimulus.

// File: rtl/smb_csr_pkg.sv
package smb_csr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CCODE, S_CNT, S_CMD, S_REG, S_WEND, S_TX, S_SKIP
  } rx_st_e;

  localparam int STAT_RD_BIT  = 0;
  localparam int STAT_ERR_BIT = 1;
endpackage

// File: rtl/smb_rx_decode.sv
module smb_rx_decode
  import smb_csr_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter logic [6:0] SLV_ADDR = 7'h52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              rdy_i,
  output logic              rx_ack_o,
  output logic              launch_o,
  output logic [ADDR_W-1:0] launch_addr_o,
  output logic              grant_o
);
  localparam int AB      = ADDR_W / 8;
  localparam int REQ_CNT = 1 + AB;
  localparam int CW      = (AB > 1) ? $clog2(AB) : 1;

  rx_st_e            st_q, st_d;
  logic              cc_seen_q;
  logic [CW-1:0]     bidx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cc_hit, reg_hit;

  always_comb begin
    st_d     = st_q;
    rx_ack_o = 1'b0;
    launch_o = 1'b0;
    grant_o  = 1'b0;
    cc_hit   = 1'b0;
    reg_hit  = 1'b0;
    if (start_i) begin
      st_d = S_ADDR;
    end else if (stop_i) begin
      launch_o = (st_q == S_WEND);
      st_d     = S_IDLE;
    end else if (rx_valid_i) begin
      unique case (st_q)
        S_ADDR: begin
          if (rx_byte_i[7:1] != SLV_ADDR) begin
            st_d = S_SKIP;
          end else if (!rx_byte_i[0]) begin
            rx_ack_o = 1'b1;
            st_d     = S_CCODE;
          end else if (cc_seen_q && rdy_i) begin
            rx_ack_o = 1'b1;
            grant_o  = 1'b1;
            st_d     = S_TX;
          end else begin
            st_d = S_SKIP;
          end
        end
        S_CCODE: begin
          rx_ack_o = 1'b1;
          cc_hit   = 1'b1;
          st_d     = S_CNT;
        end
        S_CNT: begin
          if (rx_byte_i == 8'(REQ_CNT)) begin
            rx_ack_o = 1'b1;
            st_d     = S_CMD;
          end else begin
            st_d = S_SKIP;
          end
        end
        S_CMD: begin
          if (rx_byte_i[0]) begin
            rx_ack_o = 1'b1;
            st_d     = S_REG;
          end else begin
            st_d = S_SKIP;
          end
        end
        S_REG: begin
          rx_ack_o = 1'b1;
          reg_hit  = 1'b1;
          if (bidx_q == CW'(AB - 1)) st_d = S_WEND;
        end
        default: st_d = S_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cc_seen_q <= 1'b0;
      bidx_q    <= '0;
      addr_q    <= '0;
    end else begin
      st_q <= st_d;
      if (stop_i) cc_seen_q <= 1'b0;
      else if (cc_hit) cc_seen_q <= 1'b1;
      else if (rx_valid_i && !start_i && st_q == S_ADDR) cc_seen_q <= 1'b0;
      if (st_d == S_CMD) bidx_q <= '0;
      else if (reg_hit) begin
        addr_q[bidx_q*8 +: 8] <= rx_byte_i;
        bidx_q                <= bidx_q + 1'b1;
      end
    end
  end

  assign launch_addr_o = addr_q;
endmodule

// File: rtl/smb_csr_fetch.sv
module smb_csr_fetch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rerr_i,
  output logic              rdy_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic              req_q, redo_q, rdy_q, err_q;
  logic [ADDR_W-1:0] req_addr_q, pend_q, rsp_addr_q;
  logic [DATA_W-1:0] data_q;
  logic              fire;

  assign fire = req_q && rack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      redo_q     <= 1'b0;
      rdy_q      <= 1'b0;
      err_q      <= 1'b0;
      req_addr_q <= '0;
      pend_q     <= '0;
      rsp_addr_q <= '0;
      data_q     <= '0;
    end else begin
      if (launch_i) rdy_q <= 1'b0;
      if (fire) begin
        if (launch_i) begin
          // stale answer: reissue with the new address
          req_addr_q <= launch_addr_i;
          redo_q     <= 1'b0;
        end else if (redo_q) begin
          req_addr_q <= pend_q;
          redo_q     <= 1'b0;
        end else begin
          req_q      <= 1'b0;
          rdy_q      <= 1'b1;
          err_q      <= rerr_i;
          rsp_addr_q <= req_addr_q;
          data_q     <= rerr_i ? '0 : rdata_i;
        end
      end else if (launch_i) begin
        if (req_q) begin
          redo_q <= 1'b1;
          pend_q <= launch_addr_i;
        end else begin
          req_q      <= 1'b1;
          req_addr_q <= launch_addr_i;
        end
      end
    end
  end

  assign req_o      = req_q;
  assign req_addr_o = req_addr_q;
  assign rdy_o      = rdy_q;
  assign err_o      = err_q;
  assign rsp_addr_o = rsp_addr_q;
  assign rsp_data_o = data_q;
endmodule

// File: rtl/smb_rsp_fmt.sv
module smb_rsp_fmt
  import smb_csr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              tx_next_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] rsp_addr_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic [7:0]        tx_byte_o,
  output logic [$clog2(2+ADDR_W/8+DATA_W/8)-1:0] idx_o
);
  localparam int AB = ADDR_W / 8;
  localparam int DB = DATA_W / 8;
  localparam int N  = 2 + AB + DB;
  localparam int IW = $clog2(N);

  logic [7:0]    rsp_b [N];
  logic [IW-1:0] idx_q;
  logic [7:0]    stat;

  always_comb begin
    stat               = '0;
    stat[STAT_RD_BIT]  = 1'b1;
    stat[STAT_ERR_BIT] = err_i;
  end

  assign rsp_b[0] = 8'(N - 1);
  assign rsp_b[1] = stat;

  for (genvar a = 0; a < AB; a++) begin : g_abyte
    assign rsp_b[2+a] = rsp_addr_i[a*8 +: 8];
  end
  for (genvar d = 0; d < DB; d++) begin : g_dbyte
    assign rsp_b[2+AB+d] = rsp_data_i[d*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (grant_i) idx_q <= '0;
    else if (tx_next_i && idx_q != IW'(N - 1)) idx_q <= idx_q + 1'b1;
  end

  assign tx_byte_o = rsp_b[idx_q];
  assign idx_o     = idx_q;
endmodule

// File: rtl/smb_csr_bridge.sv
module smb_csr_bridge
  import smb_csr_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 32,
  parameter logic [6:0] SLV_ADDR = 7'h52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              rx_ack_o,
  input  logic              tx_next_i,
  output logic [7:0]        tx_byte_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rerr_i
);
  localparam int IW = $clog2(2 + ADDR_W/8 + DATA_W/8);

  logic              launch, grant, rdy, err;
  logic [ADDR_W-1:0] launch_addr, rsp_addr;
  logic [DATA_W-1:0] rsp_data;
  logic [IW-1:0]     tx_idx;

  smb_rx_decode #(.ADDR_W(ADDR_W), .SLV_ADDR(SLV_ADDR)) u_dec (
    .clk_i, .rst_ni, .start_i, .stop_i, .rx_valid_i, .rx_byte_i,
    .rdy_i(rdy), .rx_ack_o, .launch_o(launch),
    .launch_addr_o(launch_addr), .grant_o(grant)
  );

  smb_csr_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk_i, .rst_ni, .launch_i(launch), .launch_addr_i(launch_addr),
    .req_o, .req_addr_o, .rack_i, .rdata_i, .rerr_i,
    .rdy_o(rdy), .err_o(err), .rsp_addr_o(rsp_addr), .rsp_data_o(rsp_data)
  );

  smb_rsp_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rsp (
    .clk_i, .rst_ni, .grant_i(grant), .tx_next_i, .err_i(err),
    .rsp_addr_i(rsp_addr), .rsp_data_i(rsp_data),
    .tx_byte_o, .idx_o(tx_idx)
  );
endmodule

// File: rtl/smb_csr_bridge_chk.sv
module smb_csr_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 stop_i,
  input logic                 rx_valid_i,
  input logic                 rx_ack_o,
  input logic                 rack_i,
  input logic                 req_o,
  input logic                 rdy,
  input logic                 err,
  input logic [$clog2(2+ADDR_W/8+DATA_W/8)-1:0] tx_idx,
  input logic [7:0]           tx_byte_o
);
  localparam int AB = ADDR_W / 8;
  localparam int IW = $clog2(2 + AB + DATA_W/8);

  p_ack_only_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ack_o |-> (rx_valid_i && !start_i && !stop_i));

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rack_i) |=> req_o);

  p_req_from_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(stop_i));

  p_new_req_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !rdy);

  p_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy && tx_idx == IW'(1)) |-> (tx_byte_o[0] && tx_byte_o[1] == err));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy && err && tx_idx >= IW'(2 + AB)) |-> (tx_byte_o == 8'h00));
endmodule

bind smb_csr_bridge smb_csr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .rx_valid_i(rx_valid_i), .rx_ack_o(rx_ack_o), .rack_i(rack_i),
  .req_o(req_o), .rdy(rdy), .err(err), .tx_idx(tx_idx), .tx_byte_o(tx_byte_o)
);

// File: tb/smb_csr_bridge_bench.sv
module smb_csr_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, stop, rv, tx_next, rack, rerr;
  logic [7:0]  rb;
  logic [31:0] rdata;
  logic        rx_ack, req;
  logic [7:0]  tx_byte;
  logic [15:0] req_addr;

  localparam logic [7:0] AW = 8'hA4;
  localparam logic [7:0] AR = 8'hA5;
  localparam logic [7:0] CC = 8'h11;

  // {addr_hi, addr_lo, data, err}
  localparam logic [48:0] VEC [4] = '{
    {8'h12, 8'h34, 32'hDEADBEEF, 1'b0},
    {8'h00, 8'h00, 32'h00000001, 1'b0},
    {8'hFF, 8'hFC, 32'hA5A55A5A, 1'b1},
    {8'h80, 8'h01, 32'h89ABCDEF, 1'b0}
  };

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  smb_csr_bridge u_smb_csr_bridge (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .rx_valid_i(rv), .rx_byte_i(rb), .rx_ack_o(rx_ack),
    .tx_next_i(tx_next), .tx_byte_o(tx_byte),
    .req_o(req), .req_addr_o(req_addr),
    .rack_i(rack), .rdata_i(rdata), .rerr_i(rerr)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic ev_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic ev_stop;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, output logic a);
    @(negedge clk); rv = 1'b1; rb = b;
    #1 a = rx_ack;
    @(negedge clk); rv = 1'b0;
  endtask

  // full request write; returns acks of the six bytes
  task automatic wr_req(input logic [7:0] cnt, input logic [7:0] cmd,
                        input logic [7:0] al, input logic [7:0] ah,
                        output logic [5:0] acks);
    ev_start;
    put(AW, acks[5]); put(CC, acks[4]); put(cnt, acks[3]);
    put(cmd, acks[2]); put(al, acks[1]); put(ah, acks[0]);
    ev_stop;
  endtask

  task automatic respond(input logic [31:0] d, input logic e);
    @(negedge clk); rack = 1'b1; rdata = d; rerr = e;
    @(negedge clk); rack = 1'b0;
  endtask

  task automatic rd_open(output logic a);
    logic t;
    ev_start; put(AW, t); put(CC, t);
    ev_start; put(AR, a);
  endtask

  task automatic rd_check(input logic [7:0] al, input logic [7:0] ah,
                          input logic [31:0] d, input logic e);
    logic [7:0] exp [8];
    exp[0] = 8'd7;
    exp[1] = {6'b0, e, 1'b1};
    exp[2] = al; exp[3] = ah;
    for (int k = 0; k < 4; k++) exp[4+k] = e ? 8'h00 : d[k*8 +: 8];
    for (int i = 0; i < 8; i++) begin
      chk((i == 1) ? "R7 status" : (i >= 4 && e) ? "R8 zero data" : "R7 byte",
          {24'b0, tx_byte}, {24'b0, exp[i]});
      tx_next = 1'b1;
      @(negedge clk); tx_next = 1'b0;
    end
    ev_stop;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] acks;
    logic a, t;
    start = 0; stop = 0; rv = 0; rb = 0; tx_next = 0; rack = 0; rdata = 0; rerr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 req after reset", {31'b0, req}, 32'd0);
    rd_open(a); ev_stop;
    chk("R10 read refused after reset", {31'b0, a}, 32'd0);

    // vector table walk
    for (int v = 0; v < 4; v++) begin
      logic [7:0] ah, al; logic [31:0] d; logic e;
      {ah, al, d, e} = VEC[v];
      wr_req(8'd3, 8'h01, al, ah, acks);
      chk("R2 request bytes acked", {26'b0, acks}, 32'h3F);
      chk("R2 req raised", {31'b0, req}, 32'd1);
      chk("R2 req address", {16'b0, req_addr}, {16'b0, ah, al});
      rd_open(a); ev_stop;
      chk("R6 read refused while pending", {31'b0, a}, 32'd0);
      repeat (2) @(negedge clk);
      chk("R2 req held", {31'b0, req}, 32'd1);
      respond(d, e);
      chk("R7 req dropped after ack", {31'b0, req}, 32'd0);
      rd_open(a);
      chk("R7 read acked when ready", {31'b0, a}, 32'd1);
      rd_check(al, ah, d, e);
    end

    // R1 wrong address then skip
    ev_start; put(8'h20, a);
    chk("R1 wrong address refused", {31'b0, a}, 32'd0);
    put(CC, a);
    chk("R1 byte after refused address", {31'b0, a}, 32'd0);
    ev_stop;
    put(AW, a);
    chk("R1 byte without START", {31'b0, a}, 32'd0);

    // R3 bad count
    wr_req(8'd4, 8'h01, 8'h10, 8'h20, acks);
    chk("R3 count byte refused", {31'b0, acks[3]}, 32'd0);
    chk("R3 no request", {31'b0, req}, 32'd0);

    // R4 write command
    wr_req(8'd3, 8'h00, 8'h10, 8'h20, acks);
    chk("R4 write command refused", {31'b0, acks[2]}, 32'd0);
    chk("R4 no request", {31'b0, req}, 32'd0);

    // R5 extra byte, then early stop
    ev_start; put(AW, t); put(CC, t); put(8'd3, t); put(8'h01, t);
    put(8'h10, t); put(8'h20, t); put(8'h30, a);
    ev_stop;
    chk("R5 extra byte refused", {31'b0, a}, 32'd0);
    chk("R5 no request after extra byte", {31'b0, req}, 32'd0);
    ev_start; put(AW, t); put(CC, t); put(8'd3, t); put(8'h01, t); put(8'h10, t);
    ev_stop;
    chk("R5 no request on early STOP", {31'b0, req}, 32'd0);

    // R6 read without command code (data still ready from last vector)
    ev_start; put(AR, a); ev_stop;
    chk("R6 read without command code refused", {31'b0, a}, 32'd0);

    // R9 new write clears ready
    wr_req(8'd3, 8'h01, 8'h44, 8'h33, acks);
    rd_open(a); ev_stop;
    chk("R9 ready cleared by new write", {31'b0, a}, 32'd0);
    // R9 replace while pending
    wr_req(8'd3, 8'h01, 8'h66, 8'h55, acks);
    chk("R9 old address held", {16'b0, req_addr}, 32'h3344);
    respond(32'h11111111, 1'b0);
    chk("R9 reissued req", {31'b0, req}, 32'd1);
    chk("R9 reissued address", {16'b0, req_addr}, 32'h5566);
    rd_open(a); ev_stop;
    chk("R9 stale ack dropped", {31'b0, a}, 32'd0);
    respond(32'h22334455, 1'b0);
    rd_open(a);
    chk("R9 read acked after reissue", {31'b0, a}, 32'd1);
    rd_check(8'h66, 8'h55, 32'h22334455, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule